// File: doc/BRIEF.md
# Dual-Issue Pairing Checker

This block decides whether two consecutive instructions in a two-wide, in-order integer pipeline may leave the issue stage in the same cycle. Each slot carries a pre-decoded descriptor with these fields:

- an instruction class
- a destination register tag with an enable bit
- two source register tags, each with an enable bit
- a flag bit: for the older slot it marks a flag write, for the younger slot a flag read
- a shifted-register-operand bit
- a two-bit immediate kind

The older slot is A and the younger slot is B. Slot B has its own valid bit.

The decision is a pair-issue bit and a three-bit reason code that explains a refusal. The block refuses a pair for any of these causes:

- a register dependence or a flag dependence
- a shared barrel shifter
- two memory loads
- two multiplies
- two floating-point arithmetic operations
- a double-precision operation paired with a floating-point load
- any divide
- any multiple-register load

The result passes through one output register. The handshake toward the issue stage is valid/ready. A new descriptor pair is accepted when the register is empty or is being drained in the same cycle.

Register tags form one namespace that covers integer and floating-point registers alike.

The class codes are:

| Class | Code |
|---|---|
| ALU | 0 |
| MUL or multiply-accumulate | 1 |
| DIV | 2 |
| single integer load | 3 |
| multiple-register load | 4 |
| single-precision FP arithmetic | 5 |
| double-precision FP arithmetic | 6 |
| FP load | 7 |

The immediate-kind codes are: 0 none, 1 small plain, 2 rotated constant.

Top module: `dual_issue_pair`

## Requirements
- R1: If either slot is class DIV (2), pair-issue is 0 and the reason code is 4.
- R2: If B reads, through an enabled source, the tag that A writes through its enabled destination, the pair is refused with reason 3.
- R3: If A writes the flags and B reads them, the pair is refused with reason 3.
- R4: A slot uses the shifter when its shift bit is set or its immediate kind is 2. Two shifter users are refused with reason 1. A kind-1 immediate is not a shifter use, so shifted operand plus small immediate pairs, and rotated immediate plus small immediate pairs.
- R5: These pairs are refused with reason 2: two loads (classes 3, 4 or 7 in any mix), and two multiplies (class 1).
- R6: A multiple-register load (class 4) in either slot never pairs; it gives reason 2 when no higher-priority cause applies.
- R7: Some floating-point pairs are allowed. An integer load (3) pairs with FP arithmetic (5 or 6). An FP load (7) pairs with single-precision arithmetic (5).
- R8: Some floating-point pairs are refused. Two FP arithmetic operations get reason 2. An FP load with double-precision arithmetic gets reason 2. An FP load whose enabled destination equals an enabled destination or source of the single-precision operation, in either slot order, gets reason 3.
- R9: Causes are ranked: divide (4) above hazard (3) above structural (2) above shifter (1). Pair-issue is 1 exactly when the code is 0.
- R10: When B is not valid, pair-issue is 0 and the reason code is 0.
- R11: An accepted pair appears on the outputs one cycle later with out_valid set. The outputs hold while out_ready is low. in_ready is high when out_valid is low or out_ready is high.
- R12: After reset, out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Descriptor pair offered |
| in_ready | output | 1 | Descriptor pair can be accepted |
| a_cls | input | 3 | Older slot class |
| a_dst | input | REG_W | Older slot destination tag |
| a_dst_en | input | 1 | Older slot writes a register |
| a_src0 | input | REG_W | Older slot source 0 tag |
| a_src0_en | input | 1 | Older slot source 0 used |
| a_src1 | input | REG_W | Older slot source 1 tag |
| a_src1_en | input | 1 | Older slot source 1 used |
| a_flg_wr | input | 1 | Older slot sets flags |
| a_shf | input | 1 | Older slot has a shifted operand |
| a_imm | input | 2 | Older slot immediate kind |
| b_vld | input | 1 | Younger slot holds an instruction |
| b_cls | input | 3 | Younger slot class |
| b_dst | input | REG_W | Younger slot destination tag |
| b_dst_en | input | 1 | Younger slot writes a register |
| b_src0 | input | REG_W | Younger slot source 0 tag |
| b_src0_en | input | 1 | Younger slot source 0 used |
| b_src1 | input | REG_W | Younger slot source 1 tag |
| b_src1_en | input | 1 | Younger slot source 1 used |
| b_flg_rd | input | 1 | Younger slot reads flags |
| b_shf | input | 1 | Younger slot has a shifted operand |
| b_imm | input | 2 | Younger slot immediate kind |
| out_valid | output | 1 | Registered decision valid |
| out_ready | input | 1 | Issue stage takes the decision |
| out_pair | output | 1 | Both instructions may issue together |
| out_why | output | 3 | Refusal reason: 0 none, 1 shifter, 2 structural, 3 hazard, 4 divide |

## Verification
Several properties are checked on every cycle:
- a divide forces reason 4 on the following output
- a flag dependence without a divide forces reason 3
- an empty younger slot yields no pairing and reason 0
- a stalled output holds its value

Other behaviour can only be shown by the bench's directed scenarios and by its cycle-by-cycle model under random descriptors and random back-pressure. This covers register-tag matching, the floating-point overlap rule in both slot orders, the shifter and immediate combinations, the structural load and multiply cases, and the full priority ranking.

// File: rtl/dual_issue_pair.sv
module dual_issue_pair #(
  parameter int REG_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [2:0]       a_cls,
  input  logic [REG_W-1:0] a_dst,
  input  logic             a_dst_en,
  input  logic [REG_W-1:0] a_src0,
  input  logic             a_src0_en,
  input  logic [REG_W-1:0] a_src1,
  input  logic             a_src1_en,
  input  logic             a_flg_wr,
  input  logic             a_shf,
  input  logic [1:0]       a_imm,
  input  logic             b_vld,
  input  logic [2:0]       b_cls,
  input  logic [REG_W-1:0] b_dst,
  input  logic             b_dst_en,
  input  logic [REG_W-1:0] b_src0,
  input  logic             b_src0_en,
  input  logic [REG_W-1:0] b_src1,
  input  logic             b_src1_en,
  input  logic             b_flg_rd,
  input  logic             b_shf,
  input  logic [1:0]       b_imm,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_pair,
  output logic [2:0]       out_why
);
  localparam logic [2:0] C_MUL = 3'd1, C_DIV = 3'd2, C_LD = 3'd3, C_LDM = 3'd4,
                         C_FSP = 3'd5, C_FDP = 3'd6, C_FLD = 3'd7;
  localparam logic [1:0] IMM_ROT = 2'd2;
  localparam logic [2:0] W_NONE = 3'd0, W_SHF = 3'd1, W_STR = 3'd2,
                         W_HAZ = 3'd3, W_DIV = 3'd4;

  function automatic logic is_load(input logic [2:0] c);
    return c == C_LD || c == C_LDM || c == C_FLD;
  endfunction

  function automatic logic is_farith(input logic [2:0] c);
    return c == C_FSP || c == C_FDP;
  endfunction

  function automatic logic hits(input logic [REG_W-1:0] t, input logic [REG_W-1:0] r,
                                input logic en);
    return en && t == r;
  endfunction

  logic a_shu, b_shu, raw, flag_dep, fp_ovl_ab, fp_ovl_ba;
  logic div_c, haz_c, str_c, shf_c;
  logic [2:0] why_n;

  assign a_shu = a_shf | (a_imm == IMM_ROT);
  assign b_shu = b_shf | (b_imm == IMM_ROT);

  assign raw = a_dst_en &
               (hits(a_dst, b_src0, b_src0_en) | hits(a_dst, b_src1, b_src1_en));
  assign flag_dep = a_flg_wr & b_flg_rd;

  assign fp_ovl_ab = a_cls == C_FLD && b_cls == C_FSP && a_dst_en &&
                     (hits(a_dst, b_dst, b_dst_en) | hits(a_dst, b_src0, b_src0_en) |
                      hits(a_dst, b_src1, b_src1_en));
  assign fp_ovl_ba = b_cls == C_FLD && a_cls == C_FSP && b_dst_en &&
                     (hits(b_dst, a_dst, a_dst_en) | hits(b_dst, a_src0, a_src0_en) |
                      hits(b_dst, a_src1, a_src1_en));

  assign div_c = a_cls == C_DIV || b_cls == C_DIV;
  assign haz_c = raw | flag_dep | fp_ovl_ab | fp_ovl_ba;
  assign str_c = (is_load(a_cls) && is_load(b_cls)) ||
                 (a_cls == C_MUL && b_cls == C_MUL) ||
                 a_cls == C_LDM || b_cls == C_LDM ||
                 (is_farith(a_cls) && is_farith(b_cls)) ||
                 (a_cls == C_FLD && b_cls == C_FDP) ||
                 (b_cls == C_FLD && a_cls == C_FDP);
  assign shf_c = a_shu & b_shu;

  always_comb begin
    if (!b_vld)     why_n = W_NONE;
    else if (div_c) why_n = W_DIV;
    else if (haz_c) why_n = W_HAZ;
    else if (str_c) why_n = W_STR;
    else if (shf_c) why_n = W_SHF;
    else            why_n = W_NONE;
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pair  <= 1'b0;
      out_why   <= W_NONE;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_pair <= b_vld && why_n == W_NONE;
        out_why  <= why_n;
      end
    end
  end
endmodule

module dual_issue_pair_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [2:0] a_cls,
  input logic [2:0] b_cls,
  input logic       b_vld,
  input logic       a_flg_wr,
  input logic       b_flg_rd,
  input logic       out_valid,
  input logic       out_ready,
  input logic       out_pair,
  input logic [2:0] out_why
);
  AST_DIV_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && b_vld && (a_cls == 3'd2 || b_cls == 3'd2))
      |=> (out_valid && !out_pair && out_why == 3'd4)); // R1
  AST_FLAG_HAZARD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && b_vld && a_flg_wr && b_flg_rd && a_cls != 3'd2 && b_cls != 3'd2)
      |=> (out_valid && !out_pair && out_why == 3'd3)); // R3
  AST_EMPTY_YOUNGER: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !b_vld) |=> (out_valid && !out_pair && out_why == 3'd0)); // R10
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pair) && $stable(out_why))); // R11
  AST_PAIR_MEANS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_pair) |-> (out_why == 3'd0)); // R9
endmodule

bind dual_issue_pair dual_issue_pair_chk u_chk (.*);

// File: tb/dual_issue_pair_bench.sv
module dual_issue_pair_bench;
  localparam int RW = 6;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic in_ready, out_valid, out_pair;
  logic [2:0] out_why;
  logic [2:0] a_cls = '0, b_cls = '0;
  logic [RW-1:0] a_dst = '0, a_src0 = '0, a_src1 = '0, b_dst = '0, b_src0 = '0, b_src1 = '0;
  logic a_dst_en = 0, a_src0_en = 0, a_src1_en = 0, a_flg_wr = 0, a_shf = 0;
  logic b_vld = 0, b_dst_en = 0, b_src0_en = 0, b_src1_en = 0, b_flg_rd = 0, b_shf = 0;
  logic [1:0] a_imm = '0, b_imm = '0;

  int checks = 0, errors = 0, cyc = 0;
  bit m_v = 0, m_p = 0;
  int m_w = 0;
  string cur_tag = "R12", m_tag = "R12";

  always #5 clk = ~clk;

  dual_issue_pair #(.REG_W(RW)) u_dual_issue_pair (.*);

  function automatic int ref_why();
    bit ld_a, ld_b, fa_a, fa_b;
    if (!b_vld) return 0;
    if (a_cls == 2 || b_cls == 2) return 4;
    if (a_dst_en && ((b_src0_en && b_src0 == a_dst) || (b_src1_en && b_src1 == a_dst))) return 3;
    if (a_flg_wr && b_flg_rd) return 3;
    if (a_cls == 7 && b_cls == 5 && a_dst_en &&
        ((b_dst_en && b_dst == a_dst) || (b_src0_en && b_src0 == a_dst) ||
         (b_src1_en && b_src1 == a_dst))) return 3;
    if (b_cls == 7 && a_cls == 5 && b_dst_en &&
        ((a_dst_en && a_dst == b_dst) || (a_src0_en && a_src0 == b_dst) ||
         (a_src1_en && a_src1 == b_dst))) return 3;
    ld_a = a_cls inside {3, 4, 7};
    ld_b = b_cls inside {3, 4, 7};
    fa_a = a_cls inside {5, 6};
    fa_b = b_cls inside {5, 6};
    if (ld_a && ld_b) return 2;
    if (a_cls == 1 && b_cls == 1) return 2;
    if (a_cls == 4 || b_cls == 4) return 2;
    if (fa_a && fa_b) return 2;
    if ((a_cls == 7 && b_cls == 6) || (b_cls == 7 && a_cls == 6)) return 2;
    if ((a_shf || a_imm == 2) && (b_shf || b_imm == 2)) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) m_v <= 0;
    else if (!m_v || out_ready) begin
      m_v <= in_valid;
      if (in_valid) begin
        m_w <= ref_why();
        m_p <= (ref_why() == 0) && b_vld;
        m_tag <= cur_tag;
      end
    end
  end

  always @(negedge clk) begin
    checks++;
    if (out_valid !== m_v || in_ready !== (!m_v || out_ready)) begin
      errors++;
      $display("FAIL %s valid/ready actual %0b/%0b expected %0b/%0b (R11)", m_tag,
               out_valid, in_ready, m_v, !m_v || out_ready);
    end else if (m_v && (out_pair !== m_p || out_why !== 3'(m_w))) begin
      errors++;
      $display("FAIL %s pair/why actual %0b/%0d expected %0b/%0d", m_tag,
               out_pair, out_why, m_p, m_w);
    end
  end

  task automatic set_a(input int c, d, de, s0, s0e, s1, s1e, fw, sh, im);
    a_cls = 3'(c); a_dst = RW'(d); a_dst_en = de[0]; a_src0 = RW'(s0); a_src0_en = s0e[0];
    a_src1 = RW'(s1); a_src1_en = s1e[0]; a_flg_wr = fw[0]; a_shf = sh[0]; a_imm = 2'(im);
  endtask

  task automatic set_b(input int v, c, d, de, s0, s0e, s1, s1e, fr, sh, im);
    b_vld = v[0]; b_cls = 3'(c); b_dst = RW'(d); b_dst_en = de[0]; b_src0 = RW'(s0);
    b_src0_en = s0e[0]; b_src1 = RW'(s1); b_src1_en = s1e[0]; b_flg_rd = fr[0];
    b_shf = sh[0]; b_imm = 2'(im);
  endtask

  task automatic issue(input string tag, input bit stall);
    @(negedge clk);
    cur_tag = tag;
    out_ready = stall ? ($urandom_range(0, 3) != 0) : 1'b1;
    in_valid = 1;
    while (!in_ready) begin
      @(negedge clk);
      out_ready = stall ? ($urandom_range(0, 3) != 0) : 1'b1;
    end
    @(posedge clk);
    #1 in_valid = 0;
  endtask

  task automatic expect_now(input string tag, input bit p, input int w);
    @(negedge clk); #1;
    checks++;
    if (!out_valid || out_pair !== p || out_why !== 3'(w)) begin
      errors++;
      $display("FAIL %s directed actual %0b/%0b/%0d expected 1/%0b/%0d", tag,
               out_valid, out_pair, out_why, p, w);
    end
  endtask

  task automatic go(input string tag, input bit p, input int w);
    issue(tag, 0);
    expect_now(tag, p, w);
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R12 out_valid actual %0b expected 0", out_valid);
    end
    rst_n = 1;
    // R1 divide
    set_a(2,1,1,2,1,3,1,0,0,0); set_b(1,0,4,1,5,1,6,1,0,0,0); go("R1", 0, 4);
    // R2 register dependence on source 1
    set_a(0,7,1,2,1,3,1,0,0,0); set_b(1,0,4,1,5,1,7,1,0,0,0); go("R2", 0, 3);
    // R2 disabled source does not match
    set_b(1,0,4,1,5,1,7,0,0,0,0); go("R2", 1, 0);
    // R3 flags
    set_a(0,7,1,2,1,3,1,1,0,0); set_b(1,0,4,1,5,1,6,1,1,0,0); go("R3", 0, 3);
    // R4 two shifted operands; rotated+shifted; shifted+small; rotated+small
    set_a(0,1,1,2,1,3,1,0,1,0); set_b(1,0,4,1,5,1,6,1,0,1,0); go("R4", 0, 1);
    set_a(0,1,1,2,1,3,0,0,0,2); go("R4", 0, 1);
    set_a(0,1,1,2,1,3,0,0,0,1); go("R4", 1, 0);
    set_b(1,0,4,1,5,1,6,0,0,0,1); set_a(0,1,1,2,1,3,0,0,0,2); go("R4", 1, 0);
    // R5 loads, multiplies
    set_a(3,1,1,2,1,3,0,0,0,0); set_b(1,7,40,1,5,1,6,0,0,0,0); go("R5", 0, 2);
    set_a(1,1,1,2,1,3,1,0,0,0); set_b(1,1,4,1,5,1,6,1,0,0,0); go("R5", 0, 2);
    // R6 multiple load with ALU
    set_a(4,1,1,2,1,3,0,0,0,0); set_b(1,0,4,1,5,1,6,1,0,0,0); go("R6", 0, 2);
    // R7 int load + DP arith; FP load + SP arith
    set_a(3,1,1,2,1,3,0,0,0,0); set_b(1,6,40,1,41,1,42,1,0,0,0); go("R7", 1, 0);
    set_a(7,33,1,2,1,3,0,0,0,0); set_b(1,5,40,1,41,1,42,1,0,0,0); go("R7", 1, 0);
    // R8 FP load dst overlaps op dst (younger load), two FP arith, FP load + DP
    set_a(5,40,1,41,1,42,1,0,0,0); set_b(1,7,40,1,2,1,3,0,0,0,0); go("R8", 0, 3);
    set_a(5,40,1,41,1,42,1,0,0,0); set_b(1,7,42,1,2,1,3,0,0,0,0); go("R8", 0, 3);
    set_b(1,6,50,1,51,1,52,1,0,0,0); go("R8", 0, 2);
    set_a(7,33,1,2,1,3,0,0,0,0); go("R8", 0, 2);
    // R9 priority: hazard over structural over shifter
    set_a(1,7,1,2,1,3,1,0,1,0); set_b(1,1,4,1,7,1,6,1,0,1,0); go("R9", 0, 3);
    set_b(1,1,4,1,8,1,6,1,0,1,0); go("R9", 0, 2);
    // R10 empty younger slot
    set_a(2,7,1,2,1,3,1,1,1,2); set_b(0,2,4,1,7,1,7,1,1,1,2); go("R10", 0, 4 * 0);
    // R11 random descriptors with back-pressure
    for (int i = 0; i < 400; i++) begin
      set_a($urandom_range(0,7), $urandom_range(0,3), $urandom_range(0,1), $urandom_range(0,3),
            $urandom_range(0,1), $urandom_range(0,3), $urandom_range(0,1), $urandom_range(0,1),
            $urandom_range(0,1), $urandom_range(0,2));
      set_b($urandom_range(0,7) != 0, $urandom_range(0,7), $urandom_range(0,3),
            $urandom_range(0,1), $urandom_range(0,3), $urandom_range(0,1), $urandom_range(0,3),
            $urandom_range(0,1), $urandom_range(0,1), $urandom_range(0,1), $urandom_range(0,2));
      issue("R11", 1);
    end
    @(negedge clk); out_ready = 1;
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule